// File: doc/BRIEF.md
# Quad-SPI PSRAM Burst Read Controller

This block reads a run of bytes from a serial PSRAM over a four-bit data bus. It takes a byte address and a byte count on a request/ready handshake. It then opens one transaction on the memory: chip select goes low, a one-byte quad read command goes out, then the address, then a fixed number of wait clocks. After that the data nibbles are sampled and packed into bytes, which leave on a valid/data stream. The serial clock toggles once per system clock while the transaction is open, so `sck_en_o` is the gate for the serial clock and clock generation sits outside this block.

The burst is linear. The block sends the start address once and then keeps clocking until the requested count has arrived. A single transaction therefore runs across the memory's 1024-byte page edges and across the top of the address space, with no second command. The setup cost of command, address and wait (14 serial clocks) is paid once per request, so long requests amortise it. A request with a length of zero is consumed and dropped. After every transaction, chip select stays high for a programmable number of idle clocks before the next request is taken.

Top module: `qspi_burst_rd`

## Requirements
- R1: After reset, `cs_no` is 1, `sck_en_o` is 0, `sio_oe_o` is 0, `rd_valid_o` is 0 and `req_ready_o` is 1.
- R2: A request accepted with `req_len_i` equal to 0 starts no transaction: `cs_no` stays 1 and `req_ready_o` is 1 again in the next cycle.
- R3: In the first two clocks with `cs_no` low, the controller drives `sio_oe_o`=1 and puts the command byte (default 0xEB) on `sio_o`, high nibble first.
- R4: The next six clocks carry the 24-bit address on `sio_o` with `sio_oe_o`=1, bits 23:20 first and bits 3:0 last.
- R5: From the ninth clock of the transaction to its end, `sio_oe_o` is 0. Six wait clocks pass, and the first data nibble is sampled at the end of the fifteenth clock.
- R6: Data bytes are built high nibble first. Each byte appears on `rd_data_o` with `rd_valid_o`=1 for one cycle, in the cycle after its low nibble was sampled. Two valid cycles are never adjacent.
- R7: A request is served by exactly one chip-select window of 14 + 2·length clocks, even when it crosses a 1024-byte page edge or the top of the address space. The bytes arrive in linear address order.
- R8: Exactly `req_len_i` bytes are delivered. The last byte appears in the first cycle in which `cs_no` is back at 1.
- R9: After a transaction, `cs_no` stays 1 for at least one clock before it falls again, and `req_ready_o` is 0 while that gap runs.
- R10: `req_ready_o` is 0 while a transaction is open. A request held during that time is not taken, and no extra transaction follows from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; one serial clock per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_addr_i | input | 24 | Start byte address |
| req_len_i | input | 16 | Number of bytes to read |
| cs_no | output | 1 | Memory chip select, active low |
| sck_en_o | output | 1 | Serial clock gate, high on every clock of an open transaction |
| sio_o | output | 4 | Nibble driven toward the memory |
| sio_oe_o | output | 1 | Output enable for `sio_o` |
| sio_i | input | 4 | Nibble received from the memory |
| rd_valid_o | output | 1 | Read byte present on `rd_data_o` |
| rd_data_o | output | 8 | Read byte |

## Verification
The last byte of a burst and the release of chip select happen in the same cycle. A request that is held through the whole burst and dropped as soon as ready returns also meets the start of the idle gap. The bench provokes both on every transaction, with random lengths, and with directed bursts across a page edge and across the top of the address space. It checks that the final byte has the value expected at that address, that chip select is already high in that cycle, that ready stays low for the gap, and that the chip-select window has exactly 14 + 2·length clocks, so the held request never opened a second window.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_WAIT,
    ST_DATA,
    ST_GAP
  } st_e;
endpackage

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
  import qspi_rd_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int WAIT_CLKS = 6,
  parameter int GAP_CLKS  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  output logic             req_ready_o,
  output logic             start_o,
  output st_e              st_o
);
  localparam int CMD_CLKS  = BYTE_W / NIB_W;
  localparam int ADDR_CLKS = ADDR_W / NIB_W;
  localparam int MAX_A     = (ADDR_CLKS > WAIT_CLKS) ? ADDR_CLKS : WAIT_CLKS;
  localparam int MAX_B     = (MAX_A > GAP_CLKS) ? MAX_A : GAP_CLKS;
  localparam int MAX_C     = (MAX_B > CMD_CLKS) ? MAX_B : CMD_CLKS;
  localparam int CNT_W     = $clog2(MAX_C) + 1;
  localparam int NL_W      = LEN_W + 1;

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NL_W-1:0]  nib_left_q;

  assign req_ready_o = (st_q == ST_IDLE);
  assign start_o     = req_ready_o && req_valid_i && (req_len_i != '0);
  assign st_o        = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      nib_left_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start_o) begin
            st_q       <= ST_CMD;
            nib_left_q <= {req_len_i, 1'b0};
          end
        end
        ST_CMD: if (cnt_q == CNT_W'(CMD_CLKS - 1)) begin
          st_q  <= ST_ADDR;
          cnt_q <= '0;
        end
        ST_ADDR: if (cnt_q == CNT_W'(ADDR_CLKS - 1)) begin
          st_q  <= ST_WAIT;
          cnt_q <= '0;
        end
        ST_WAIT: if (cnt_q == CNT_W'(WAIT_CLKS - 1)) begin
          st_q  <= ST_DATA;
          cnt_q <= '0;
        end
        ST_DATA: begin
          cnt_q      <= '0;
          nib_left_q <= nib_left_q - 1'b1;
          if (nib_left_q == NL_W'(1)) st_q <= ST_GAP;
        end
        ST_GAP: if (cnt_q == CNT_W'(GAP_CLKS - 1)) begin
          st_q  <= ST_IDLE;
          cnt_q <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_rd_hdr.sv
module qspi_rd_hdr
  import qspi_rd_pkg::*;
#(
  parameter int               ADDR_W   = 24,
  parameter logic [BYTE_W-1:0] CMD_CODE = 8'hEB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NIB_W-1:0]  nib_o
);
  localparam int HDR_W = BYTE_W + ADDR_W;

  logic [HDR_W-1:0] sreg_q;

  // command then address, most significant nibble leaves first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (load_i)  sreg_q <= {CMD_CODE, addr_i};
    else if (shift_i) sreg_q <= {sreg_q[HDR_W-NIB_W-1:0], {NIB_W{1'b0}}};
  end

  assign nib_o = sreg_q[HDR_W-1 -: NIB_W];
endmodule

// File: rtl/qspi_rd_asm.sv
module qspi_rd_asm
  import qspi_rd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [NIB_W-1:0]  sio_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  logic             lo_phase_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_phase_q <= 1'b0;
      hi_q       <= '0;
      valid_o    <= 1'b0;
      data_o     <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        lo_phase_q <= 1'b0;
      end else begin
        lo_phase_q <= ~lo_phase_q;
        if (!lo_phase_q) begin
          hi_q <= sio_i;
        end else begin
          data_o  <= {hi_q, sio_i};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qspi_burst_rd.sv
module qspi_burst_rd
  import qspi_rd_pkg::*;
#(
  parameter int               ADDR_W    = 24,
  parameter int               LEN_W     = 16,
  parameter logic [BYTE_W-1:0] CMD_CODE  = 8'hEB,
  parameter int               WAIT_CLKS = 6,
  parameter int               GAP_CLKS  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              cs_no,
  output logic              sck_en_o,
  output logic [NIB_W-1:0]  sio_o,
  output logic              sio_oe_o,
  input  logic [NIB_W-1:0]  sio_i,
  output logic              rd_valid_o,
  output logic [BYTE_W-1:0] rd_data_o
);
  st_e  st;
  logic start;
  logic hdr_phase;
  logic active;

  qspi_rd_seq #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .WAIT_CLKS(WAIT_CLKS),
    .GAP_CLKS (GAP_CLKS)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_len_i  (req_len_i),
    .req_ready_o(req_ready_o),
    .start_o    (start),
    .st_o       (st)
  );

  assign hdr_phase = (st == ST_CMD) || (st == ST_ADDR);
  assign active    = hdr_phase || (st == ST_WAIT) || (st == ST_DATA);

  qspi_rd_hdr #(
    .ADDR_W  (ADDR_W),
    .CMD_CODE(CMD_CODE)
  ) i_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start),
    .shift_i(hdr_phase),
    .addr_i (req_addr_i),
    .nib_o  (sio_o)
  );

  qspi_rd_asm i_asm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (st == ST_DATA),
    .sio_i  (sio_i),
    .valid_o(rd_valid_o),
    .data_o (rd_data_o)
  );

  assign cs_no    = ~active;
  assign sck_en_o = active;
  assign sio_oe_o = hdr_phase;
endmodule

// File: rtl/qspi_burst_rd_chk.sv
module qspi_burst_rd_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [LEN_W-1:0] req_len_i,
  input logic             cs_no,
  input logic             sio_oe_o,
  input logic             rd_valid_o
);
  assert_zero_len_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_len_i == '0) |=> (cs_no && req_ready_o));

  assert_cmd_driven_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> sio_oe_o);

  assert_oe_inside_cs_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o |-> !cs_no);

  assert_byte_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  assert_gap_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> !req_ready_o);

  assert_start_from_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(req_ready_o));

  assert_no_ready_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);
endmodule

bind qspi_burst_rd qspi_burst_rd_chk #(.LEN_W(LEN_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_len_i  (req_len_i),
  .cs_no      (cs_no),
  .sio_oe_o   (sio_oe_o),
  .rd_valid_o (rd_valid_o)
);

// File: tb/test_qspi_burst_rd.sv
module test_qspi_burst_rd;
  localparam logic [7:0] CMD = 8'hEB;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [23:0] req_addr_i = '0;
  logic [15:0] req_len_i = '0;
  logic        cs_no, sck_en_o, sio_oe_o, rd_valid_o;
  logic [3:0]  sio_o;
  logic [3:0]  sio_i = '0;
  logic [7:0]  rd_data_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // monitor state
  logic [23:0] exp_addr = '0;
  int exp_len = 0;
  int n = 0;
  int got = 0;
  int cs_low = 0;
  int cs_falls = 0;
  logic cs_prev = 1'b1;

  always #5 clk_i = ~clk_i;

  qspi_burst_rd i_qspi_burst_rd (.*);

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // memory model and per-cycle protocol checks
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (rd_valid_o) begin
        chk(rd_data_o == mem_byte(exp_addr + 24'(got)), "R6 data", rd_data_o,
            mem_byte(exp_addr + 24'(got)));
        got++;
        if (got == exp_len) chk(cs_no == 1'b1, "R8 last byte with cs high", cs_no, 1);
      end
      if (!cs_no) begin
        if (cs_prev) cs_falls++;
        cs_low++;
        chk(sck_en_o == 1'b1, "R7 sck gate", sck_en_o, 1);
        if (n < 2) begin
          chk(sio_oe_o && sio_o == (n == 0 ? CMD[7:4] : CMD[3:0]), "R3 cmd",
              {sio_oe_o, sio_o}, {1'b1, (n == 0 ? CMD[7:4] : CMD[3:0])});
        end else if (n < 8) begin
          chk(sio_oe_o && sio_o == exp_addr[23 - 4*(n-2) -: 4], "R4 addr",
              {sio_oe_o, sio_o}, {1'b1, exp_addr[23 - 4*(n-2) -: 4]});
        end else begin
          chk(!sio_oe_o, "R5 oe off", sio_oe_o, 0);
        end
        if (n >= 14) begin
          logic [7:0] b;
          b = mem_byte(exp_addr + 24'((n - 14) / 2));
          sio_i = ((n - 14) % 2 == 0) ? b[7:4] : b[3:0];
        end else begin
          sio_i = 4'h0;
        end
        n++;
      end else begin
        n = 0;
        sio_i = 4'h0;
      end
      cs_prev = cs_no;
    end
  end

  // issue a request; hold a spurious request while busy (R10)
  task automatic burst(logic [23:0] a, int len);
    int gap;
    @(negedge clk_i); #1;
    exp_addr = a; exp_len = len; got = 0; cs_low = 0; cs_falls = 0;
    req_valid_i = 1'b1; req_addr_i = a; req_len_i = 16'(len);
    @(negedge clk_i); #1;
    req_addr_i = ~a; req_len_i = 16'd3;
    chk(!req_ready_o, "R10 busy ready", req_ready_o, 0);
    gap = 0;
    while (!req_ready_o) begin
      if (cs_no) gap++;
      @(negedge clk_i); #1;
    end
    req_valid_i = 1'b0;
    chk(gap >= 1, "R9 idle gap", gap, 1);
    chk(got == len, "R8 byte count", got, len);
    chk(cs_falls == 1, "R7 one window", cs_falls, 1);
    chk(cs_low == 14 + 2*len, "R7 window length", cs_low, 14 + 2*len);
    repeat (2) begin
      @(negedge clk_i); #1;
      chk(cs_no && got == len, "R10 held request ignored", {cs_no, 16'(got)}, {1'b1, 16'(len)});
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    #1;
    chk(cs_no && !sck_en_o && !sio_oe_o && !rd_valid_o && req_ready_o, "R1 reset",
        {cs_no, sck_en_o, sio_oe_o, rd_valid_o, req_ready_o}, 5'b10001);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(cs_no && !sck_en_o && !sio_oe_o && !rd_valid_o && req_ready_o, "R1 after release",
        {cs_no, sck_en_o, sio_oe_o, rd_valid_o, req_ready_o}, 5'b10001);

    // R2 zero length
    req_valid_i = 1'b1; req_addr_i = 24'h123456; req_len_i = '0;
    @(negedge clk_i); #1;
    req_valid_i = 1'b0;
    chk(cs_no && req_ready_o, "R2 zero length", {cs_no, req_ready_o}, 2'b11);
    repeat (3) begin
      @(negedge clk_i); #1;
      chk(cs_no && !rd_valid_o, "R2 no transaction", {cs_no, rd_valid_o}, 2'b10);
    end

    burst(24'h000010, 1);
    burst(24'h0003FF, 2);    // R7 page edge
    burst(24'h0007F0, 40);   // R7 page edge, long burst
    burst(24'hFFFFFC, 8);    // R7 address-space top
    for (int i = 0; i < 20; i++)
      burst(24'($urandom), 1 + int'($urandom % 24));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule